// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes into start/stop framed characters on a single serial output line. A producer hands a byte to a one-entry holding register through a valid/ready handshake. When transmission is enabled and the shift stage is free, or is finishing its final stop bit, the byte moves into the shift stage and goes out least significant bit first. Bit timing comes from an external baud tick: every bit lasts a fixed number of ticks.

The frame shape comes from static control inputs, which are sampled when a byte enters the shift stage. In the standard mode the character is 7 or 8 bits long, with an optional odd or even parity bit. In the multiprocessor mode the character is always 8 bits, and an address/data marker bit takes the slot that parity would use. Either mode ends with one or two stop bits. Clearing the enable never cuts a character short; it only stops the next one from starting. A busy flag and a holding-empty flag report progress.

Top module: `async_tx_frame`

## Requirements
- R1: After reset, txd is 1, busy is 0, hold_empty is 1 and wr_ready is 1. While busy is 0, txd stays 1.
- R2: Bit 0 of a frame is a low start bit. The data bits follow, least significant first. Each bit lasts OVS (16) baud ticks, except that the start bit of a frame begun from idle may be one clock shorter. The control inputs are sampled when the byte enters the shift stage.
- R3: With mp_mode=0 and par_en=1, one parity bit follows the data bits. With par_odd=0 it makes the count of ones over data plus parity even; with par_odd=1 it makes that count odd.
- R4: The frame ends with two high stop bits when stop_two=1 and with one when stop_two=0. This holds in both modes.
- R5: With mp_mode=0 and len8=0, only wr_data[6:0] is sent, and wr_data[7] has no effect on the line. With len8=1, all 8 bits are sent.
- R6: With mp_mode=1, 8 data bits are always sent, whatever len8 is. Then addr_mark is sent (1 = address frame, 0 = data frame) in the slot after the data, and par_en is ignored.
- R7: While tx_en=0, no frame starts. A byte in the holding register stays there, so hold_empty stays 0 and wr_ready stays 0.
- R8: If tx_en is cleared during a frame, that frame is sent in full, and a byte waiting in the holding register is not started.
- R9: wr_ready equals hold_empty, and the holding register can be written while a frame shifts out. If it is full and tx_en=1 when the last stop bit ends, the next start bit follows with no idle time.
- R10: busy is 1 from the start bit through the end of the last stop bit. hold_empty rises in the same cycle that the start bit begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse, OVS pulses per bit |
| tx_en | input | 1 | Transmit enable |
| mp_mode | input | 1 | 0 standard mode, 1 multiprocessor mode |
| par_en | input | 1 | Append parity (standard mode only) |
| par_odd | input | 1 | 1 odd parity, 0 even parity |
| stop_two | input | 1 | 1 two stop bits, 0 one stop bit |
| len8 | input | 1 | 1 eight data bits, 0 seven (standard mode only) |
| addr_mark | input | 1 | Marker bit value in multiprocessor mode |
| wr_valid | input | 1 | Byte offered to the holding register |
| wr_data | input | DATA_W (8) | Byte to send |
| wr_ready | output | 1 | Holding register can accept a byte |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | A frame is on the line |
| hold_empty | output | 1 | Holding register is empty |

## Verification
The critical coincidence is the end of a frame's last stop bit falling in the same cycle as the transfer of the next held byte into the shift stage. In that cycle the bit counter expires and a new frame is loaded together, and the clear of tx_en can land close to it. The bench provokes this by writing a new byte as soon as hold_empty rises, so the holding register is full while every frame shifts. It judges the result by requiring that busy never drops between frames and that consecutive start edges are one frame length apart. A second case clears tx_en while a byte waits, and the bench checks that the running frame completes and the waiting byte stays put.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

   typedef struct packed {
      logic mp;
      logic par_en;
      logic par_odd;
      logic stop_two;
      logic len8;
      logic addr_mark;
   } txcfg_t;

endpackage

// File: rtl/atx_hold.sv
module atx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic              full,
   output logic [DATA_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full <= 1'b0;
         q    <= '0;
      end else if (take) begin
         full <= 1'b0;
      end else if (wr_valid && !full) begin
         full <= 1'b1;
         q    <= wr_data;
      end
   end

   // R9
   take_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> full);

   // R7
   held_byte_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !take) |=> (full && $stable(q)));

endmodule

// File: rtl/atx_bittimer.sv
module atx_bittimer #(
   parameter int OVS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic run,
   input  logic clear,
   output logic bit_end
);

   localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;

   logic [CW-1:0] cnt;
   logic [CW-1:0] nxt;

   generate
      if ((OVS & (OVS - 1)) == 0) begin : g_wrap
         assign nxt = cnt + CW'(1);
      end else begin : g_cmp
         assign nxt = (cnt == CW'(OVS - 1)) ? '0 : cnt + CW'(1);
      end
   endgenerate

   assign bit_end = run && tick && (cnt == CW'(OVS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt <= '0;
      else if (clear)       cnt <= '0;
      else if (run && tick) cnt <= nxt;
   end

   // R2
   bit_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_end |=> (cnt == '0));

endmodule

// File: rtl/atx_shifter.sv
module atx_shifter
   import async_tx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  txcfg_t            cfg,
   input  logic [DATA_W-1:0] data,
   input  logic              take,
   input  logic              bit_end,
   output logic              txd,
   output logic              busy,
   output logic              last_bit
);

   localparam int FRAME_W = DATA_W + 4;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   logic [FRAME_W-1:0] sr;
   logic [CNT_W-1:0]   left;
   logic [FRAME_W-1:0] nvec;
   logic [CNT_W-1:0]   ncnt;
   logic [DATA_W-1:0]  dm;
   logic               short_len, ext_on, ext_bit, slot;

   always_comb begin
      short_len = !(cfg.mp || cfg.len8);
      dm        = data;
      if (short_len) dm[DATA_W-1] = 1'b0;
      ext_on    = cfg.mp || cfg.par_en;
      ext_bit   = cfg.mp ? cfg.addr_mark : (cfg.par_odd ^ (^dm));
      slot      = ext_on ? ext_bit : 1'b1;
      if (short_len) nvec = {3'b111, slot, dm[DATA_W-2:0], 1'b0};
      else           nvec = {2'b11, slot, dm, 1'b0};
      ncnt = CNT_W'(DATA_W + 2);
      if (short_len)    ncnt = ncnt - CNT_W'(1);
      if (ext_on)       ncnt = ncnt + CNT_W'(1);
      if (cfg.stop_two) ncnt = ncnt + CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr   <= '1;
         left <= '0;
      end else if (take) begin
         sr   <= nvec;
         left <= ncnt;
      end else if (bit_end) begin
         sr   <= {1'b1, sr[FRAME_W-1:1]};
         left <= left - CNT_W'(1);
      end
   end

   assign txd      = sr[0];
   assign busy     = (left != '0);
   assign last_bit = (left == CNT_W'(1));

   // R2
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !txd);

endmodule

// File: rtl/async_tx_frame.sv
module async_tx_frame
   import async_tx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              tx_en,
   input  logic              mp_mode,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              stop_two,
   input  logic              len8,
   input  logic              addr_mark,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   output logic              txd,
   output logic              busy,
   output logic              hold_empty
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (OVS < 2) begin : g_bad_ovs
         $error("OVS must be at least 2");
      end
   endgenerate

   txcfg_t            cfg;
   logic              hold_full;
   logic [DATA_W-1:0] hold_q;
   logic              take, bit_end, last_bit;

   always_comb begin
      cfg.mp        = mp_mode;
      cfg.par_en    = par_en;
      cfg.par_odd   = par_odd;
      cfg.stop_two  = stop_two;
      cfg.len8      = len8;
      cfg.addr_mark = addr_mark;
   end

   assign take       = hold_full && tx_en && (!busy || (bit_end && last_bit));
   assign wr_ready   = !hold_full;
   assign hold_empty = !hold_full;

   atx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .take(take), .full(hold_full), .q(hold_q)
   );

   atx_bittimer #(.OVS(OVS)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .run(busy),
      .clear(take), .bit_end(bit_end)
   );

   atx_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .cfg(cfg), .data(hold_q), .take(take),
      .bit_end(bit_end), .txd(txd), .busy(busy), .last_bit(last_bit)
   );

   // R1
   idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);

   // R7
   disabled_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en && !busy) |=> !busy);

   // R10
   busy_ends_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(bit_end));

   // R10
   empty_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_empty) |-> (busy && !txd));

endmodule

// File: tb/tb_async_tx_frame.sv
module tb_async_tx_frame;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic baud_tick = 1'b0;
   logic tx_en = 1'b0;
   logic mp_mode = 1'b0, par_en = 1'b0, par_odd = 1'b0;
   logic stop_two = 1'b0, len8 = 1'b1, addr_mark = 1'b0;
   logic wr_valid = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic wr_ready, txd, busy, hold_empty;

   int total = 0, fail = 0, cyc = 0, chained = 0;
   bit gap = 1'b1, have_prev = 1'b0;
   int prev_t = 0, prev_n = 0;

   logic [15:0] q_v[$];
   int          q_n[$];
   logic [5:0]  q_c[$];

   async_tx_frame dut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
      .mp_mode(mp_mode), .par_en(par_en), .par_odd(par_odd),
      .stop_two(stop_two), .len8(len8), .addr_mark(addr_mark),
      .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
      .txd(txd), .busy(busy), .hold_empty(hold_empty)
   );

   always #2 clk = ~clk;
   always @(negedge clk) baud_tick <= ~baud_tick;
   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) if (!busy) gap = 1'b1;

   task automatic chk(input string req, input int act, input int exp, input string what);
      total++;
      if (act != exp) begin
         fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int make_frame(input logic [7:0] d, input logic [5:0] c,
                                     output logic [15:0] v);
      int n, nd, ones;
      logic mp, pe, po, s2, l8, am;
      {mp, pe, po, s2, l8, am} = c;
      v = '1; n = 0; ones = 0;
      v[n] = 1'b0; n = n + 1;
      nd = (mp || l8) ? 8 : 7;
      for (int i = 0; i < nd; i++) begin
         v[n] = d[i]; n = n + 1;
         if (d[i]) ones++;
      end
      if (mp) begin
         v[n] = am; n = n + 1;
      end else if (pe) begin
         v[n] = ((ones % 2) == 1) ^ po; n = n + 1;
      end
      v[n] = 1'b1; n = n + 1;
      if (s2) begin v[n] = 1'b1; n = n + 1; end
      return n;
   endfunction

   function automatic string tag_of(input int b, input logic [5:0] c);
      int nd;
      nd = (c[5] || c[1]) ? 8 : 7;
      if (b == 0) return "R2";
      if (b <= nd) return c[5] ? "R6" : (c[1] ? "R2" : "R5");
      if (b == nd + 1 && (c[5] || c[4])) return c[5] ? "R6" : "R3";
      return "R4";
   endfunction

   task automatic send(input logic [7:0] d);
      logic [15:0] v;
      logic [5:0]  c;
      int n;
      @(negedge clk);
      while (!wr_ready) @(negedge clk);
      c = {mp_mode, par_en, par_odd, stop_two, len8, addr_mark};
      n = make_frame(d, c, v);
      q_v.push_back(v); q_n.push_back(n); q_c.push_back(c);
      wr_data = d; wr_valid = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic wait_empty();
      @(negedge clk);
      while (!hold_empty) @(negedge clk);
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (!hold_empty || busy || q_n.size() != 0) @(negedge clk);
   endtask

   task automatic set_cfg(input logic [5:0] c);
      {mp_mode, par_en, par_odd, stop_two, len8, addr_mark} = c;
   endtask

   // line monitor: finds start edges, samples mid-bit
   initial begin
      logic [15:0] v;
      logic [5:0]  c;
      int n, delta;
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         if (txd === 1'b0) begin
            if (have_prev && !gap) begin
               delta = cyc - prev_t;
               chained++;
               chk("R9", int'(delta >= prev_n * 32 - 1 && delta <= prev_n * 32), 1,
                   "back-to-back start spacing");
            end
            gap = 1'b0;
            have_prev = 1'b1;
            if (q_n.size() == 0) begin
               chk("R7", 1, 0, "frame started with nothing expected");
               repeat (420) @(negedge clk);
            end else begin
               v = q_v.pop_front(); n = q_n.pop_front(); c = q_c.pop_front();
               prev_t = cyc; prev_n = n;
               repeat (15) @(negedge clk);
               for (int b = 0; b < n; b++) begin
                  if (b > 0) repeat (32) @(negedge clk);
                  chk(tag_of(b, c), int'(txd), int'(v[b]), $sformatf("frame bit %0d", b));
                  chk("R10", int'(busy), 1, $sformatf("busy in bit %0d", b));
               end
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      total++; fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fail, total);
      $finish;
   end

   initial begin
      int lo;
      void'($urandom(32'd4242));
      repeat (4) @(negedge clk);
      // R1 reset state
      chk("R1", int'(txd), 1, "txd in reset");
      chk("R1", int'(busy), 0, "busy in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", int'(txd), 1, "txd after reset");
      chk("R1", int'(busy), 0, "busy after reset");
      chk("R1", int'(hold_empty), 1, "hold_empty after reset");
      chk("R1", int'(wr_ready), 1, "wr_ready after reset");

      // R7: disabled, byte held, nothing on the line
      set_cfg(6'b000010);
      send(8'hA5);
      lo = 0;
      repeat (600) begin
         @(negedge clk);
         if (!txd || busy) lo++;
      end
      chk("R7", lo, 0, "line activity while disabled");
      chk("R7", int'(hold_empty), 0, "byte kept while disabled");
      chk("R7", int'(wr_ready), 0, "wr_ready while disabled");
      tx_en = 1'b1;
      wait_empty();

      // R8: disable mid-frame with a byte waiting
      send(8'h3C);
      repeat (100) @(negedge clk);
      tx_en = 1'b0;
      repeat (700) @(negedge clk);
      chk("R8", int'(busy), 0, "frame finished after disable");
      chk("R8", int'(hold_empty), 0, "waiting byte not started");
      chk("R8", q_n.size(), 1, "pending frames after disable");
      tx_en = 1'b1;
      wait_idle();

      // R5 / R3 / R4 / R9: 7-bit even parity, two stops, chained
      set_cfg(6'b010110 & 6'b110110);
      set_cfg({1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0});
      send(8'hFF);
      wait_empty();
      send(8'h80);
      wait_empty();
      set_cfg({1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0});
      send(8'h5A);
      wait_idle();

      // R6: multiprocessor, parity and short length requested but ignored
      set_cfg({1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1});
      send(8'hC3);
      wait_empty();
      set_cfg({1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0});
      send(8'h81);
      wait_idle();

      // random mix
      for (int k = 0; k < 40; k++) begin
         wait_empty();
         if ($urandom % 5 == 0) wait_idle();
         set_cfg(6'($urandom));
         send(8'($urandom));
      end
      wait_idle();
      repeat (40) @(negedge clk);
      chk("R9", int'(chained > 0), 1, "at least one chained frame seen");
      chk("R2", q_n.size(), 0, "all frames emitted");
      chk("R1", int'(txd), 1, "line idle at end");
      $display("%0d/%0d checks passed", total - fail, total);
      $finish;
   end

endmodule